// File: doc/BRIEF.md
# Serial flash command sequencer

This block runs one serial-flash access for every accepted write to its command register. Software first loads an address word and, for writes, a data word, then writes a command word naming the opcode, the chip to select, how many address bytes (0 to 3), dummy bytes (0 to 15) and data bytes (0 to 4) to move, and the direction. The engine then clocks the bytes over a half-duplex SPI link in mode 3.

A command may ask that chip select stay low once it finishes. The next command to the same chip then continues the transaction: it sends no opcode, only its own address, dummy and data bytes. A flash access of any length is thus a chain of short commands. A command with all lengths zero only raises chip select, if the chain is held open and the keep flag is clear. A status word shows a pending bit while a command runs, and a sticky error bit for any command the engine refuses.

Top module: `sflash_cmd_seq`

## Requirements
- R1: After reset every chip-select line is high, the serial clock is high, and the status word reads zero.
- R2: The command word carries the opcode in bits 7:0, the direction in bit 8 (1 = write), the data length in bits 11:9, the keep flag in bit 15, the dummy length in bits 19:16, the address length in bits 22:20 and the chip index in bits 26:24. The opcode is sent first, and only when chip select was not already held. If chip select is not held and all lengths are zero, the opcode alone goes out.
- R3: Address bytes go out most significant first. With a length of n, bits 8n-1:0 of the address register are sent.
- R4: Each dummy byte goes out as 0x00, after the address and before the data.
- R5: For a write, data byte k comes from bits 8k+7:8k of the data register (byte 0 first on the wire). During a read, MOSI sends 0x00.
- R6: After a read of n bytes, the data register holds the received byte k in bits 8k+7:8k and zero above byte n-1. It holds these values by the cycle in which the pending bit clears.
- R7: With the keep flag set, chip select stays low after the command. With it clear, chip select rises as the command ends. A zero-length command on a held chip sends no bytes and only releases.
- R8: Status bit 22 reads 1 for exactly 2 + N*(16*HALF_CYC+1) cycles after an accepted command write, where N is the number of bytes sent. Chip select is low for all of that time.
- R9: A command write while pending is ignored and sets status bit 29. Writing 1 to bit 29 of the status word clears it.
- R10: A command naming a different chip while another chip is held sets bit 29 and is ignored. The held line stays low.
- R11: A command with chip index >= NUM_CS, address length > 3 or data length > 4 sets bit 29 and is ignored.
- R12: Register offsets are 0x88 status, 0x8C command, 0x90 address and 0x94 data. Chip index i drives only csN[i] low.
- R13: SPI mode 3: SCK idles high, MOSI changes only on a falling edge, MISO is sampled on the rising edge, and bits go out most significant first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | BUS_AW | Register byte offset |
| busWe | input | 1 | Register write strobe |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for busAddr, combinational |
| csN | output | NUM_CS | Chip-select lines, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
A wrong byte counter or a skipped phase changes the length of the pending window. The bench compares the pending bit and chip selects against its model on every cycle, so such a fault shows within one byte time (33 cycles at the default divider). A wrong phase order or a held/released slip in the chain shows when the bytes captured on the wire, or the chip-select level after the command, differ from the expected list at the end of that same command. Refused commands are caught in the following cycle through the error bit and an unchanged wire.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;

  // command word field positions (decoded by software and by this block)
  localparam int OPC_LSB  = 0;
  localparam int DIR_BIT  = 8;
  localparam int DLEN_LSB = 9;
  localparam int KEEP_BIT = 15;
  localparam int DUM_LSB  = 16;
  localparam int ALEN_LSB = 20;
  localparam int CSI_LSB  = 24;

  // status bits
  localparam int STAT_PEND_BIT = 22;
  localparam int STAT_ERR_BIT  = 29;

  // register byte offsets
  localparam logic [7:0] OFF_STAT = 8'h88;
  localparam logic [7:0] OFF_CMD  = 8'h8C;
  localparam logic [7:0] OFF_ADDR = 8'h90;
  localparam logic [7:0] OFF_DATA = 8'h94;

  typedef enum logic [1:0] {PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA} phase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       start;
    logic [7:0] txByte;
  } dp_ctrl_t;

  // datapath -> control
  typedef struct packed {
    logic       done;
    logic [7:0] rxByte;
  } dp_stat_t;

endpackage

// File: rtl/sfseq_shifter.sv
module sfseq_shifter
  import sfseq_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  dp_ctrl_t ctl,
  output dp_stat_t st,
  output logic     sck,
  output logic     mosi,
  input  logic     miso
);

  localparam int DIV_W = $clog2(HALF_CYC + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

  logic             busy;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       shReg;
  logic             sckR;
  logic             mosiR;
  logic             doneR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      shReg  <= '0;
      sckR   <= 1'b1;
      mosiR  <= 1'b0;
      doneR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (ctl.start && !busy) begin
        busy   <= 1'b1;
        sckR   <= 1'b0;
        divCnt <= '0;
        bitCnt <= '0;
        shReg  <= ctl.txByte;
        mosiR  <= ctl.txByte[7];
      end else if (busy) begin
        if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          if (!sckR) begin
            sckR  <= 1'b1;
            shReg <= {shReg[6:0], miso};
          end else if (bitCnt == 3'd7) begin
            busy  <= 1'b0;
            doneR <= 1'b1;
          end else begin
            sckR   <= 1'b0;
            bitCnt <= bitCnt + 3'd1;
            mosiR  <= shReg[7];
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign sck       = sckR;
  assign mosi      = mosiR;
  assign st.done   = doneR;
  assign st.rxByte = shReg;

endmodule

// File: rtl/sfseq_ctrl.sv
module sfseq_ctrl
  import sfseq_pkg::*;
#(
  parameter int NUM_CS     = 3,
  parameter int ADDR_BYTES = 3,
  parameter int DATA_W     = 32,
  parameter int BUS_AW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       cmdWord,
  output logic [31:0]       addrWord,
  output logic [DATA_W-1:0] dataWord,
  output logic              errBit,
  output logic              pending,
  output logic              csActive,
  output logic [2:0]        csIdx,
  output dp_ctrl_t          dpCtl,
  input  dp_stat_t          dpSt
);

  localparam int MAX_DBYTES = DATA_W / 8;

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_SHIFT, S_FIN} state_t;

  state_t     state;
  logic       sendOpc;
  logic [2:0] aLeft;
  logic [3:0] dLeft;
  logic [2:0] xLeft;
  logic [2:0] xIdx;
  logic [2:0] curIdx;
  phase_t     curPhase;

  // decode of an incoming command word
  logic [2:0] newIdx, newAlen, newDlen;
  logic [3:0] newDum;
  logic       isCmdWr, badFields, conflict, reject, accept;

  assign newIdx  = busWdata[CSI_LSB +: 3];
  assign newAlen = busWdata[ALEN_LSB +: 3];
  assign newDlen = busWdata[DLEN_LSB +: 3];
  assign newDum  = busWdata[DUM_LSB +: 4];

  assign isCmdWr   = busWe && (busAddr == BUS_AW'(OFF_CMD));
  assign badFields = (int'(newIdx) >= NUM_CS) || (int'(newAlen) > ADDR_BYTES)
                     || (int'(newDlen) > MAX_DBYTES);
  assign conflict  = csActive && (newIdx != csIdx);
  assign reject    = isCmdWr && ((state != S_IDLE) || badFields || conflict);
  assign accept    = isCmdWr && !reject;

  // choose the next byte from the counters still open
  phase_t pickPh;
  logic   anyLeft;
  always_comb begin
    anyLeft = 1'b1;
    pickPh  = PH_OPC;
    if (sendOpc)          pickPh = PH_OPC;
    else if (aLeft != '0) pickPh = PH_ADDR;
    else if (dLeft != '0) pickPh = PH_DUMMY;
    else if (xLeft != '0) pickPh = PH_DATA;
    else                  anyLeft = 1'b0;
  end

  logic              isWrite;
  logic [31:0]       addrShift;
  logic [DATA_W-1:0] dataShift;
  logic [7:0]        txSel;
  logic              launchNow;

  assign isWrite   = cmdWord[DIR_BIT];
  assign addrShift = addrWord >> {aLeft - 3'd1, 3'b000};
  assign dataShift = dataWord >> {xIdx, 3'b000};

  always_comb begin
    case (pickPh)
      PH_OPC:  txSel = cmdWord[OPC_LSB +: 8];
      PH_ADDR: txSel = addrShift[7:0];
      PH_DATA: txSel = isWrite ? dataShift[7:0] : 8'h00;
      default: txSel = 8'h00;
    endcase
  end

  assign launchNow    = (state == S_LAUNCH) || ((state == S_SHIFT) && dpSt.done);
  assign dpCtl.start  = launchNow && anyLeft;
  assign dpCtl.txByte = txSel;
  assign pending      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cmdWord  <= '0;
      addrWord <= '0;
      dataWord <= '0;
      errBit   <= 1'b0;
      csActive <= 1'b0;
      csIdx    <= '0;
      sendOpc  <= 1'b0;
      aLeft    <= '0;
      dLeft    <= '0;
      xLeft    <= '0;
      xIdx     <= '0;
      curIdx   <= '0;
      curPhase <= PH_OPC;
    end else begin
      // plain register writes
      if (busWe && busAddr == BUS_AW'(OFF_ADDR)) addrWord <= busWdata;
      if (busWe && busAddr == BUS_AW'(OFF_DATA)) dataWord <= busWdata[DATA_W-1:0];
      if (busWe && busAddr == BUS_AW'(OFF_STAT) && busWdata[STAT_ERR_BIT]) errBit <= 1'b0;
      if (reject) errBit <= 1'b1;

      case (state)
        S_IDLE: begin
          if (accept) begin
            cmdWord  <= busWdata;
            sendOpc  <= !csActive;
            csActive <= 1'b1;
            csIdx    <= newIdx;
            aLeft    <= newAlen;
            dLeft    <= newDum;
            xLeft    <= newDlen;
            xIdx     <= '0;
            if (!busWdata[DIR_BIT] && newDlen != '0) dataWord <= '0;
            state    <= S_LAUNCH;
          end
        end
        S_LAUNCH, S_SHIFT: begin
          if (state == S_SHIFT && dpSt.done && curPhase == PH_DATA && !isWrite)
            dataWord[{curIdx, 3'b000} +: 8] <= dpSt.rxByte;
          if (launchNow) begin
            if (anyLeft) begin
              curPhase <= pickPh;
              state    <= S_SHIFT;
              case (pickPh)
                PH_OPC:   sendOpc <= 1'b0;
                PH_ADDR:  aLeft   <= aLeft - 3'd1;
                PH_DUMMY: dLeft   <= dLeft - 4'd1;
                default: begin
                  xLeft  <= xLeft - 3'd1;
                  xIdx   <= xIdx + 3'd1;
                  curIdx <= xIdx;
                end
              endcase
            end else begin
              state <= S_FIN;
            end
          end
        end
        default: begin // S_FIN
          csActive <= cmdWord[KEEP_BIT];
          state    <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/sflash_cmd_seq.sv
module sflash_cmd_seq
  import sfseq_pkg::*;
#(
  parameter int NUM_CS     = 3,
  parameter int HALF_CYC   = 2,
  parameter int ADDR_BYTES = 3,
  parameter int BUS_AW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_CS-1:0] csN,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  localparam int DATA_W = 32;

  dp_ctrl_t          dpCtl;
  dp_stat_t          dpSt;
  logic [31:0]       cmdWord, addrWord;
  logic [DATA_W-1:0] dataWord;
  logic              errSig, pendingSig, csActive;
  logic [2:0]        csIdx;

  sfseq_ctrl #(
    .NUM_CS(NUM_CS), .ADDR_BYTES(ADDR_BYTES), .DATA_W(DATA_W), .BUS_AW(BUS_AW)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .cmdWord(cmdWord), .addrWord(addrWord), .dataWord(dataWord),
    .errBit(errSig), .pending(pendingSig),
    .csActive(csActive), .csIdx(csIdx),
    .dpCtl(dpCtl), .dpSt(dpSt)
  );

  sfseq_shifter #(.HALF_CYC(HALF_CYC)) shifter (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .st(dpSt),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign csN[g] = !(csActive && (int'(csIdx) == g));
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      BUS_AW'(OFF_STAT): begin
        busRdata[STAT_PEND_BIT] = pendingSig;
        busRdata[STAT_ERR_BIT]  = errSig;
      end
      BUS_AW'(OFF_CMD):  busRdata = cmdWord;
      BUS_AW'(OFF_ADDR): busRdata = addrWord;
      BUS_AW'(OFF_DATA): busRdata = dataWord;
      default:           busRdata = '0;
    endcase
  end

endmodule

// File: rtl/sfseq_checker.sv
module sfseq_checker
  import sfseq_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int BUS_AW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CS-1:0] csN,
  input logic              sck,
  input logic              mosi,
  input logic [BUS_AW-1:0] busAddr,
  input logic              busWe,
  input logic              pending,
  input logic              errBit,
  input logic [31:0]       dataWord
);

  // R13: clock rests high whenever no chip is selected
  a_r13_sck_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |-> sck);

  // R13: MOSI only moves on a falling edge
  a_r13_mosi_stable: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  // R12: never more than one line selected
  a_r12_one_cs: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1);

  // R8: a chip is selected for the whole pending window
  a_r8_pending_cs_low: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !(&csN));

  // R6: read data already settled when pending drops
  a_r6_data_settled: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pending) && !$past(busWe)) |-> $stable(dataWord));

  // R9: a command write during a busy command raises the error flag
  a_r9_busy_write_err: assert property (@(posedge clk) disable iff (!rstN)
    (pending && busWe && busAddr == BUS_AW'(OFF_CMD)) |=> errBit);

endmodule

bind sflash_cmd_seq sfseq_checker #(.NUM_CS(NUM_CS), .BUS_AW(BUS_AW)) chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
  .busAddr(busAddr), .busWe(busWe), .pending(pendingSig),
  .errBit(errSig), .dataWord(dataWord)
);

// File: tb/sflash_cmd_seq_test.sv
module sflash_cmd_seq_test;

  localparam int HALF     = 2;
  localparam int BYTE_CYC = 16 * HALF + 1;
  localparam logic [7:0] A_STAT = 8'h88;
  localparam logic [7:0] A_CMD  = 8'h8C;
  localparam logic [7:0] A_ADDR = 8'h90;
  localparam logic [7:0] A_DATA = 8'h94;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = A_STAT;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  csN;
  logic        sck, mosi;
  logic        miso = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  sflash_cmd_seq uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .csN(csN),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int k);
    return 8'((k * 41 + 90) & 255);
  endfunction

  // ---------------- flash-side model ----------------
  logic [7:0] gotBytes[$];
  logic       prevSck = 1'b1;
  logic [7:0] inSh = '0;
  int         inBits = 0;
  int         outBits = 0;
  int         kOut = 0;
  logic [7:0] outByte = '0;

  always @(negedge clk) begin
    if (&csN) begin
      inBits = 0; outBits = 0; kOut = 0;
    end else begin
      if (prevSck && !sck) begin
        if (outBits == 0) begin
          outByte = fbyte(kOut);
          kOut++;
        end
        miso = outByte[7 - outBits];
        outBits = (outBits + 1) % 8;
      end
      if (!prevSck && sck) begin
        inSh = {inSh[6:0], mosi};
        inBits++;
        if (inBits == 8) begin
          gotBytes.push_back(inSh);
          inBits = 0;
        end
      end
    end
    prevSck = sck;
  end

  // ---------------- reference model state ----------------
  bit         mHeld = 1'b0;
  int         mIdx = 0;
  int         mWire = 0;
  bit         mErr = 1'b0;
  logic [7:0] expBytes[$];

  function automatic logic [2:0] csExp();
    return mHeld ? ~(3'b001 << mIdx) : 3'b111;
  endfunction

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busAddr = A_STAT;
  endtask

  // issue one command and track it cycle by cycle
  task automatic doCmd(input logic [31:0] cmd, input logic [31:0] addr,
                       input logic [31:0] wdata, input int intrudeAt,
                       input string tag);
    int idx, alen, dum, dlen, n, dcyc, base;
    bit wr, keep, opc, bad;
    logic [31:0] expRd;
    idx  = int'(cmd[26:24]);
    alen = int'(cmd[22:20]);
    dum  = int'(cmd[19:16]);
    dlen = int'(cmd[11:9]);
    wr   = cmd[8];
    keep = cmd[15];
    bad  = (idx >= 3) || (alen > 3) || (dlen > 4) || (mHeld && idx != mIdx);

    busWrite(A_ADDR, addr);
    busWrite(A_DATA, wdata);
    @(negedge clk);
    busWe = 1'b1; busAddr = A_CMD; busWdata = cmd;

    if (bad) begin
      mErr = 1'b1;
      @(negedge clk);
      busWe = 1'b0; busAddr = A_STAT;
      #1;
      check(busRdata[22] == 1'b0, {tag, " rejected command stays idle"}, {31'd0, busRdata[22]}, 32'd0);
      check(busRdata[29] == 1'b1, {tag, " error flag on rejected command"}, {31'd0, busRdata[29]}, 32'd1);
      check(csN == csExp(), {tag, " chip select untouched by rejected command"}, {29'd0, csN}, {29'd0, csExp()});
      check(gotBytes.size() == 0, {tag, " no wire bytes for rejected command"}, gotBytes.size(), 32'd0);
      gotBytes.delete();
      return;
    end

    opc = !mHeld;
    n = (opc ? 1 : 0) + alen + dum + dlen;
    dcyc = 2 + n * BYTE_CYC;
    if (opc) expBytes.push_back(cmd[7:0]);
    for (int a = alen - 1; a >= 0; a--) expBytes.push_back(addr[8*a +: 8]);
    for (int z = 0; z < dum; z++) expBytes.push_back(8'h00);
    for (int j = 0; j < dlen; j++) expBytes.push_back(wr ? wdata[8*j +: 8] : 8'h00);
    base = mWire + (opc ? 1 : 0) + alen + dum;
    expRd = '0;
    for (int j = 0; j < dlen; j++) expRd[8*j +: 8] = fbyte(base + j);
    mWire += n;
    mHeld = 1'b1;
    mIdx = idx;
    if (intrudeAt >= 0) mErr = 1'b1;

    for (int i = 0; i < dcyc; i++) begin
      @(negedge clk);
      if (i == intrudeAt) begin
        busWe = 1'b1; busAddr = A_CMD; busWdata = 32'h0000_0003 | (cmd & 32'h0700_0000);
        continue;
      end
      busWe = 1'b0; busAddr = A_STAT;
      #1;
      check(busRdata[22] == 1'b1, {tag, " R8 pending inside window"}, {31'd0, busRdata[22]}, 32'd1);
      check(csN == csExp(), {tag, " R12 selected line during command"}, {29'd0, csN}, {29'd0, csExp()});
    end

    if (!keep) begin
      mHeld = 1'b0;
      mWire = 0;
    end
    @(negedge clk);
    #1;
    check(busRdata[22] == 1'b0, {tag, " R8 pending cleared on time"}, {31'd0, busRdata[22]}, 32'd0);
    check(busRdata[29] == mErr, {tag, " R9 error flag after command"}, {31'd0, busRdata[29]}, {31'd0, mErr});
    check(csN == csExp(), {tag, " R7 chip select after command"}, {29'd0, csN}, {29'd0, csExp()});
    if (!wr && dlen > 0) begin
      busAddr = A_DATA;
      #1;
      check(busRdata == expRd, {tag, " R6 read data word"}, busRdata, expRd);
      busAddr = A_STAT;
    end
    check(gotBytes.size() == expBytes.size(), {tag, " wire byte count"}, gotBytes.size(), expBytes.size());
    for (int q = 0; q < expBytes.size() && q < gotBytes.size(); q++)
      check(gotBytes[q] == expBytes[q], {tag, " wire byte value"}, {24'd0, gotBytes[q]}, {24'd0, expBytes[q]});
    gotBytes.delete();
    expBytes.delete();
  endtask

  task automatic clearErr(input string tag);
    busWrite(A_STAT, 32'h2000_0000);
    mErr = 1'b0;
    #1;
    check(busRdata[29] == 1'b0, {tag, " R9 error cleared by write-one"}, {31'd0, busRdata[29]}, 32'd0);
  endtask

  function automatic logic [31:0] mk(input int op, input int idx, input int alen,
                                     input int dum, input int dlen, input bit wr,
                                     input bit keep);
    logic [31:0] c;
    c = '0;
    c[7:0]   = 8'(op);
    c[8]     = wr;
    c[11:9]  = 3'(dlen);
    c[15]    = keep;
    c[19:16] = 4'(dum);
    c[22:20] = 3'(alen);
    c[26:24] = 3'(idx);
    return c;
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(csN == 3'b111, "R1 chip selects high after reset", {29'd0, csN}, 32'h7);
    check(sck == 1'b1, "R1 R13 clock idles high", {31'd0, sck}, 32'd1);
    check(busRdata == 32'd0, "R1 status zero after reset", busRdata, 32'd0);

    // R2 opcode only
    doCmd(mk(8'h06, 0, 0, 0, 0, 1'b1, 1'b0), 32'h0, 32'h0, -1, "R2 opcode-only");
    // R3 R6 3-byte address read of 4 bytes on chip 1
    doCmd(mk(8'h03, 1, 3, 0, 4, 1'b0, 1'b0), 32'hFF12_3456, 32'h0, -1, "R3 R6 read4");
    // R3 R4 R6 2-byte address, one dummy, 2-byte read on chip 2
    doCmd(mk(8'h0B, 2, 2, 1, 2, 1'b0, 1'b0), 32'h00AB_CDEF, 32'h0, -1, "R4 R6 dummy read2");
    // R5 write with keep
    doCmd(mk(8'h02, 0, 3, 0, 3, 1'b1, 1'b1), 32'h0001_0203, 32'h4433_2211, -1, "R5 R7 write keep");
    // R2 R7 chained write: no opcode
    doCmd(mk(8'h02, 0, 0, 0, 4, 1'b1, 1'b1), 32'h0, 32'h8877_6655, -1, "R2 R7 chained write");
    // R10 other chip while held
    doCmd(mk(8'h03, 1, 0, 0, 1, 1'b0, 1'b0), 32'h0, 32'h0, -1, "R10 conflict");
    clearErr("R10");
    // R7 chained read that releases
    doCmd(mk(8'h02, 0, 0, 0, 1, 1'b0, 1'b0), 32'h0, 32'hFFFF_FFFF, -1, "R6 R7 chained read release");
    // R7 open then zero-length close
    doCmd(mk(8'h9F, 2, 0, 0, 1, 1'b0, 1'b1), 32'h0, 32'h0, -1, "R7 open");
    doCmd(mk(8'h9F, 2, 0, 0, 0, 1'b0, 1'b0), 32'h0, 32'h0, -1, "R7 zero-length close");
    // R9 write during pending
    doCmd(mk(8'h05, 1, 1, 2, 2, 1'b0, 1'b0), 32'h0000_0077, 32'h0, 5, "R9 busy write");
    clearErr("R9");
    // R11 illegal fields
    doCmd(mk(8'h03, 0, 0, 0, 5, 1'b0, 1'b0), 32'h0, 32'h0, -1, "R11 dlen5");
    clearErr("R11");
    doCmd(mk(8'h03, 0, 4, 0, 1, 1'b0, 1'b0), 32'h0, 32'h0, -1, "R11 alen4");
    clearErr("R11");
    doCmd(mk(8'h03, 3, 1, 0, 1, 1'b0, 1'b0), 32'h0, 32'h0, -1, "R11 idx3");
    clearErr("R11");
    // R13 idle after all commands
    @(negedge clk);
    check(sck == 1'b1 && csN == 3'b111, "R13 idle link", {28'd0, sck, csN}, 32'hF);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nBad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule